// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block decides whether exclusive stores from several cores may go to a shared memory port. Each core offers one request at a time on a valid/ready channel. A request is one of four kinds: a no-op, a load-exclusive, a store-exclusive or a plain store, and it carries an address and write data. A store-exclusive succeeds only if no write of any kind reached its address after the core's load-exclusive. The memory value does not matter. A location that is changed and then restored still makes the store-exclusive fail.

Reservations are kept in a small table. Each entry holds one address that has been used atomically and a bitmask with one bit per core. A sparse filter bitmap, indexed by the low address bits, marks addresses that have ever been used atomically. A plain store searches the table only when its filter bit is set. At most one request is accepted per cycle, so the single memory port is never oversubscribed. The outcome appears on registered outputs one cycle after the request is accepted.

Back-pressure rules: a core's `req_ready` is high only while its `req_valid` is high and no lower-numbered core has `req_valid` high. A request is accepted on a rising edge where valid and ready are both high. A core must hold its request stable until it is accepted. The memory side and the status side have no back-pressure.

Top module: `llsc_monitor`

## Requirements
- R1: In each cycle, `req_ready` is given to exactly the lowest-indexed core with `req_valid` high, and to no core when none is valid. The effects of an accepted request appear on `mem_*` and `rsp_*` in the following cycle.
- R2: A load-exclusive (op code 2'b01) gives the requesting core a reservation on the address. It writes no memory and produces no status.
- R3: A store-exclusive (op code 2'b10) from a core that holds a reservation on the address writes the data to memory and reports status 0 (success). It then clears every core's reservation on that address.
- R4: A store-exclusive without a reservation on the address writes no memory and reports status 1 (failure).
- R5: A plain store (op code 2'b11) always writes memory and produces no status. It clears all reservations on its address.
- R6: A store-exclusive fails after any intervening write to the address, even when the memory value has been restored to what was read (ABA).
- R7: A core holds at most one reservation. A new load-exclusive drops the core's reservation on any other address.
- R8: A new tracked address takes the lowest-indexed unused table entry. When no entry is unused, it takes a victim chosen round robin, starting at entry 0. The victim's reservations are lost, so store-exclusives to the evicted address fail.
- R9: Every tracked address has its filter bit set. A plain store whose filter bit is clear writes memory and leaves all reservations intact.
- R10: A no-op request (op code 2'b00) is accepted. It writes no memory, produces no status and leaves all reservations intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | NCORE | Per-core request valid |
| req_ready | output | NCORE | Per-core request accepted (fixed priority) |
| req_op | input | 2*NCORE | Per-core op code: 00 no-op, 01 load-excl, 10 store-excl, 11 plain store |
| req_addr | input | AW*NCORE | Per-core address |
| req_data | input | DW*NCORE | Per-core write data |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory write address |
| mem_wdata | output | DW | Memory write data |
| rsp_valid | output | 1 | Store-exclusive status valid |
| rsp_core | output | CW | Core the status belongs to |
| rsp_fail | output | 1 | Status: 0 success, 1 failure |

## Verification
The bench builds the block with three cores, a two-entry table, 8-bit addresses and data, and an 8-bit filter. With only two entries, evictions happen after just two addresses are tracked, and the round-robin victim order can be checked within a few requests. With an 8-bit filter, several tracked addresses share one filter bit, while a plain store to an address with a clear filter bit can still be placed next to a live reservation. Three cores are enough to cover priority contention and a plain store from a third party breaking another core's reservation.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_LDX   = 2'b01,
    OP_STX   = 2'b10,
    OP_STORE = 2'b11
  } llsc_op_e;
endpackage

// File: rtl/llsc_arbiter.sv
module llsc_arbiter #(
  parameter int NCORE = 4,
  parameter int CW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCORE-1:0] req,
  output logic [NCORE-1:0] gnt,
  output logic [CW-1:0]    gnt_idx,
  output logic             gnt_any
);
  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int i = 0; i < NCORE; i++) begin
      if (req[i] && !gnt_any) begin
        gnt[i]  = 1'b1;
        gnt_idx = CW'(i);
        gnt_any = 1'b1;
      end
    end
  end

  // R1
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  // R1
  gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
endmodule

// File: rtl/llsc_filter.sv
module llsc_filter #(
  parameter int FBITS = 16,
  parameter int FW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [FW-1:0]    q_idx,
  output logic             q_hit,
  input  logic             set_en,
  input  logic [FW-1:0]    set_idx,
  output logic [FBITS-1:0] bits_o
);
  logic [FBITS-1:0] bits_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits_q <= '0;
    else if (set_en) bits_q[set_idx] <= 1'b1;
  end

  assign q_hit  = bits_q[q_idx];
  assign bits_o = bits_q;
endmodule

// File: rtl/llsc_table.sv
module llsc_table
  import llsc_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 16,
  parameter int NENT  = 4,
  parameter int CW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  llsc_op_e          op,
  input  logic [CW-1:0]     core,
  input  logic [AW-1:0]     addr,
  input  logic              filt_hit,
  output logic              sc_ok,
  output logic              alloc_en,
  output logic [NENT-1:0]   ent_valid,
  output logic [NENT*AW-1:0] ent_addr
);
  localparam int EW = (NENT > 1) ? $clog2(NENT) : 1;

  logic [NENT-1:0]  vld;
  logic [AW-1:0]    tag [NENT];
  logic [NCORE-1:0] msk [NENT];
  logic [EW-1:0]    vptr;

  logic [NENT-1:0] hit;
  logic            hit_any, free_any;
  logic [EW-1:0]   hit_idx, free_idx, alloc_idx;

  always_comb begin
    hit_any  = 1'b0;
    hit_idx  = '0;
    free_any = 1'b0;
    free_idx = '0;
    for (int e = 0; e < NENT; e++) begin
      hit[e] = vld[e] && (tag[e] == addr);
      if (hit[e] && !hit_any) begin
        hit_any = 1'b1;
        hit_idx = EW'(e);
      end
      if (!vld[e] && !free_any) begin
        free_any = 1'b1;
        free_idx = EW'(e);
      end
    end
    alloc_idx = free_any ? free_idx : vptr;
  end

  assign sc_ok    = act && (op == OP_STX) && hit_any && msk[hit_idx][core];
  assign alloc_en = act && (op == OP_LDX) && !hit_any;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld  <= '0;
      vptr <= '0;
      for (int e = 0; e < NENT; e++) begin
        tag[e] <= '0;
        msk[e] <= '0;
      end
    end else if (act) begin
      unique case (op)
        OP_LDX: begin
          for (int e = 0; e < NENT; e++) msk[e][core] <= 1'b0;
          if (hit_any) begin
            msk[hit_idx][core] <= 1'b1;
          end else begin
            vld[alloc_idx] <= 1'b1;
            tag[alloc_idx] <= addr;
            msk[alloc_idx] <= NCORE'(1) << core;
            if (!free_any) vptr <= (vptr == EW'(NENT - 1)) ? '0 : vptr + 1'b1;
          end
        end
        OP_STX: if (sc_ok) msk[hit_idx] <= '0;
        OP_STORE: if (filt_hit && hit_any) msk[hit_idx] <= '0;
        default: ;
      endcase
    end
  end

  always_comb begin
    for (int e = 0; e < NENT; e++) ent_addr[e*AW +: AW] = tag[e];
  end
  assign ent_valid = vld;

  for (genvar c = 0; c < NCORE; c++) begin : g_col
    logic [NENT-1:0] col;
    always_comb for (int e = 0; e < NENT; e++) col[e] = msk[e][c];
    // R7
    one_resv_per_core_chk: assert property (@(posedge clk) disable iff (!rst_n) $countones(col) <= 1);
  end

  // R3
  sc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_ok |=> !(|msk[$past(hit_idx)]));
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
  import llsc_pkg::*;
#(
  parameter int NCORE = 4,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NENT  = 4,
  parameter int FBITS = 16,
  localparam int CW   = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int FW   = (FBITS > 1) ? $clog2(FBITS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCORE-1:0]   req_valid,
  output logic [NCORE-1:0]   req_ready,
  input  logic [2*NCORE-1:0] req_op,
  input  logic [AW*NCORE-1:0] req_addr,
  input  logic [DW*NCORE-1:0] req_data,
  output logic               mem_we,
  output logic [AW-1:0]      mem_addr,
  output logic [DW-1:0]      mem_wdata,
  output logic               rsp_valid,
  output logic [CW-1:0]      rsp_core,
  output logic               rsp_fail
);
  logic [CW-1:0] g_idx;
  logic          g_any;

  llsc_arbiter #(.NCORE(NCORE), .CW(CW)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req_valid),
    .gnt(req_ready), .gnt_idx(g_idx), .gnt_any(g_any)
  );

  llsc_op_e       s_op;
  logic [AW-1:0]  s_addr;
  logic [DW-1:0]  s_data;
  assign s_op   = llsc_op_e'(req_op[g_idx*2 +: 2]);
  assign s_addr = req_addr[g_idx*AW +: AW];
  assign s_data = req_data[g_idx*DW +: DW];

  logic             f_hit, sc_ok, alloc_en;
  logic [FBITS-1:0] f_bits;
  logic [NENT-1:0]  ent_valid;
  logic [NENT*AW-1:0] ent_addr;

  llsc_filter #(.FBITS(FBITS), .FW(FW)) u_filt (
    .clk(clk), .rst_n(rst_n),
    .q_idx(s_addr[FW-1:0]), .q_hit(f_hit),
    .set_en(alloc_en), .set_idx(s_addr[FW-1:0]),
    .bits_o(f_bits)
  );

  llsc_table #(.NCORE(NCORE), .AW(AW), .NENT(NENT), .CW(CW)) u_tab (
    .clk(clk), .rst_n(rst_n), .act(g_any), .op(s_op), .core(g_idx),
    .addr(s_addr), .filt_hit(f_hit), .sc_ok(sc_ok), .alloc_en(alloc_en),
    .ent_valid(ent_valid), .ent_addr(ent_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      rsp_valid <= 1'b0;
      rsp_core  <= '0;
      rsp_fail  <= 1'b0;
    end else begin
      mem_we    <= g_any && ((s_op == OP_STORE) || sc_ok);
      rsp_valid <= g_any && (s_op == OP_STX);
      rsp_fail  <= !sc_ok;
      if (g_any) begin
        mem_addr  <= s_addr;
        mem_wdata <= s_data;
        rsp_core  <= g_idx;
      end
    end
  end

  for (genvar e = 0; e < NENT; e++) begin : g_fchk
    // R9
    filter_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ent_valid[e] |-> f_bits[ent_addr[e*AW +: FW]]);
  end
  // R3
  pass_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fail) |-> mem_we);
  // R4
  fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fail) |-> !mem_we);
endmodule

// File: tb/llsc_monitor_bench.sv
module llsc_monitor_bench;
  localparam int NCORE = 3, AW = 8, DW = 8, NENT = 2, FBITS = 8, CW = 2;

  logic clk = 0, rst_n = 0;
  logic [NCORE-1:0] req_valid = '0;
  logic [NCORE-1:0] req_ready;
  logic [2*NCORE-1:0] req_op = '0;
  logic [AW*NCORE-1:0] req_addr = '0;
  logic [DW*NCORE-1:0] req_data = '0;
  logic mem_we, rsp_valid, rsp_fail;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [CW-1:0] rsp_core;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  llsc_monitor #(.NCORE(NCORE), .AW(AW), .DW(DW), .NENT(NENT), .FBITS(FBITS)) u_llsc_monitor (
    .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_data,
    .mem_we, .mem_addr, .mem_wdata, .rsp_valid, .rsp_core, .rsp_fail
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // vector: {req#(4), core(2), op(2), addr(8), data(8), we, rsp, fail}
  localparam int NV = 24;
  localparam logic [26:0] VEC [NV] = '{
    {4'd2,  2'd0, 2'b01, 8'h10, 8'h00, 3'b000},  // R2 LL
    {4'd3,  2'd0, 2'b10, 8'h10, 8'h05, 3'b110},  // R3 pass
    {4'd4,  2'd0, 2'b10, 8'h10, 8'h05, 3'b011},  // R4 fail
    {4'd2,  2'd1, 2'b01, 8'h10, 8'h00, 3'b000},
    {4'd5,  2'd2, 2'b11, 8'h10, 8'h07, 3'b100},  // R5 store
    {4'd5,  2'd1, 2'b10, 8'h10, 8'h01, 3'b011},  // R5 broken
    {4'd2,  2'd0, 2'b01, 8'h20, 8'h00, 3'b000},
    {4'd6,  2'd1, 2'b11, 8'h20, 8'h09, 3'b100},  // R6 B
    {4'd6,  2'd1, 2'b11, 8'h20, 8'h00, 3'b100},  // R6 back to A
    {4'd6,  2'd0, 2'b10, 8'h20, 8'h01, 3'b011},  // R6 ABA fails
    {4'd7,  2'd0, 2'b01, 8'h10, 8'h00, 3'b000},
    {4'd7,  2'd0, 2'b01, 8'h20, 8'h00, 3'b000},
    {4'd7,  2'd0, 2'b10, 8'h10, 8'h01, 3'b011},  // R7 old dropped
    {4'd7,  2'd0, 2'b10, 8'h20, 8'h02, 3'b110},  // R7 new kept
    {4'd9,  2'd2, 2'b01, 8'h20, 8'h00, 3'b000},
    {4'd9,  2'd0, 2'b11, 8'h33, 8'h03, 3'b100},  // R9 filter miss
    {4'd9,  2'd2, 2'b10, 8'h20, 8'h04, 3'b110},  // R9 intact
    {4'd10, 2'd1, 2'b01, 8'h10, 8'h00, 3'b000},
    {4'd10, 2'd0, 2'b00, 8'h10, 8'hAA, 3'b000},  // R10 no-op
    {4'd10, 2'd1, 2'b10, 8'h10, 8'h06, 3'b110},  // R10 intact
    {4'd8,  2'd1, 2'b01, 8'h10, 8'h00, 3'b000},
    {4'd8,  2'd2, 2'b01, 8'h40, 8'h00, 3'b000},  // R8 evicts 0x10
    {4'd8,  2'd1, 2'b10, 8'h10, 8'h06, 3'b011},  // R8 evicted fails
    {4'd8,  2'd2, 2'b10, 8'h40, 8'h08, 3'b110}   // R8 new passes
  };

  task automatic put(input int c, input logic [1:0] op, input logic [7:0] a, input logic [7:0] d);
    req_valid[c] = 1'b1;
    req_op[c*2 +: 2] = op;
    req_addr[c*AW +: AW] = a;
    req_data[c*DW +: DW] = d;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset / idle state
    chk(req_ready == 0, "R1", "idle ready", req_ready, 0);
    chk(mem_we == 0 && rsp_valid == 0, "R1", "reset outputs", {mem_we, rsp_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_we == 0 && rsp_valid == 0, "R1", "after reset", {mem_we, rsp_valid}, 0);

    for (int i = 0; i < NV; i++) begin
      string rq;
      logic [26:0] v;
      int c;
      v  = VEC[i];
      c  = int'(v[22:21]);
      rq = $sformatf("R%0d", v[26:23]);
      put(c, v[20:19], v[18:11], v[10:3]);
      #1;
      chk(req_ready == (3'b1 << c), "R1", "ready", req_ready, 3'b1 << c);
      @(negedge clk);
      req_valid = '0;
      chk(mem_we == v[2], rq, $sformatf("vec%0d we", i), mem_we, v[2]);
      chk(rsp_valid == v[1], rq, $sformatf("vec%0d rsp_valid", i), rsp_valid, v[1]);
      if (v[1]) begin
        chk(rsp_fail == v[0], rq, $sformatf("vec%0d rsp_fail", i), rsp_fail, v[0]);
        chk(rsp_core == CW'(c), rq, $sformatf("vec%0d rsp_core", i), rsp_core, c);
      end
      if (v[2]) begin
        chk(mem_addr == v[18:11], rq, $sformatf("vec%0d addr", i), mem_addr, v[18:11]);
        chk(mem_wdata == v[10:3], rq, $sformatf("vec%0d data", i), mem_wdata, v[10:3]);
      end
    end

    // R1 contention: both cores reserve 0x60, then both store-exclusive at once
    put(0, 2'b01, 8'h60, 8'h00); @(negedge clk); req_valid = '0;
    put(1, 2'b01, 8'h60, 8'h00); @(negedge clk); req_valid = '0;
    put(0, 2'b10, 8'h60, 8'h11);
    put(1, 2'b10, 8'h60, 8'h22);
    #1;
    chk(req_ready == 3'b001, "R1", "contention ready", req_ready, 1);
    @(negedge clk);
    req_valid[0] = 1'b0;
    chk(rsp_valid && !rsp_fail && rsp_core == 0, "R1", "winner pass", {rsp_valid, rsp_fail, rsp_core}, 3'b100);
    chk(mem_wdata == 8'h11, "R3", "winner data", mem_wdata, 8'h11);
    #1;
    chk(req_ready == 3'b010, "R1", "second ready", req_ready, 2);
    @(negedge clk);
    req_valid = '0;
    chk(rsp_valid && rsp_fail && rsp_core == 1, "R1", "loser fails", {rsp_valid, rsp_fail, rsp_core}, 3'b111);
    chk(!mem_we, "R4", "loser no write", mem_we, 0);
    @(negedge clk);
    chk(!rsp_valid && !mem_we, "R1", "outputs one cycle", {rsp_valid, mem_we}, 0);

    // R4 store-exclusive to never-tracked address
    put(2, 2'b10, 8'h77, 8'h01); @(negedge clk); req_valid = '0;
    chk(rsp_valid && rsp_fail, "R4", "untracked fail", {rsp_valid, rsp_fail}, 3);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule